// File: doc/BRIEF.md
# Event status and enable register block

This block gathers up to 128 event inputs into one byte-addressed register window and signals a single shared, level-style interrupt line. The lower half of the window holds sticky status bytes. Each status bit latches a rising edge of its synchronized event input. The upper half holds enable bytes that decide which latched events may raise the interrupt.

Software reads a status byte to see the latched event state of eight pins. It writes ones to acknowledge, which clears those bits. It masks or unmasks a pin by a read-modify-write of the matching enable byte. The window length in bytes is a parameter, and the pin count follows from it. The block does not classify events as edge or level; that is left to software.

Top module: `evt_regblk`

## Requirements
- R1: For a window of BLK_BYTES bytes (nonzero, even, at most 32), HALF = BLK_BYTES/2. Status bytes occupy addresses 0..HALF-1 and enable bytes occupy HALF..BLK_BYTES-1. There are HALF*8 pins. Pin n lives in byte n/8 of each half, at bit n mod 8.
- R2: A status bit becomes 1 after a rising edge of its event input, seen through a SYNC_STAGES-flop synchronizer, whatever its enable bit holds. It stays 1 after the input falls.
- R3: Writing a status byte clears each bit whose written value is 1. Bits written as 0 are left unchanged.
- R4: When a rising edge reaches a status bit in the same cycle as a write of 1 to that bit, the bit ends up 1.
- R5: Writing an enable byte replaces that byte with the written data, and a read returns the value written. All enable bytes are 0 after reset.
- R6: irq is 1 exactly while some pin has both its status bit and its enable bit at 1. It drops when the last such pin is acknowledged or masked.
- R7: Reads at addresses BLK_BYTES and above return 0x00. Writes there change no status bit and no enable bit.
- R8: rdata is registered. It shows the addressed byte in the cycle after rd_en is sampled, and it holds its value when rd_en is low. After reset, rdata, all status bits and irq are 0.
- R9: An event input held high sets its status bit only once. After the bit is acknowledged while the input is still high, the bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | BLK_BYTES*4 | Asynchronous event inputs, one per pin |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Shared interrupt, high while any enabled status bit is set |

## Verification
The bench builds the block with BLK_BYTES = 6 and ADDR_W = 5, which gives 24 pins, three status bytes at 0..2 and three enable bytes at 3..5. The 5-bit address reaches 26 out-of-window addresses, so reads and writes past the end can be checked. The upper half starts at an odd offset, which a decode that assumes a power-of-two split would get wrong. The default synchronizer depth lets the bench time an acknowledge write to land in the same cycle as a synchronized rising edge.

// File: rtl/evt_regblk_pkg.sv
package evt_regblk_pkg;

  localparam int unsigned BITS_PER_BYTE = 8;

  function automatic int unsigned pin_byte(input int unsigned pin);
    return pin / BITS_PER_BYTE;
  endfunction

  function automatic int unsigned pin_bit(input int unsigned pin);
    return pin % BITS_PER_BYTE;
  endfunction

  function automatic int unsigned pin_count(input int unsigned blk_bytes);
    return (blk_bytes / 2) * BITS_PER_BYTE;
  endfunction

  function automatic logic blk_len_ok(input int unsigned blk_bytes);
    return (blk_bytes != 0) && ((blk_bytes % 2) == 0) && (blk_bytes <= 32);
  endfunction

endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
  parameter int unsigned NPINS       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_in,
  output logic [NPINS-1:0] rise
);
  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q;
  logic [NPINS-1:0]                  prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= evt_in;
      for (int s = 1; s < int'(SYNC_STAGES); s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_vec,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] sts_q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/evt_enable_bank.sv
module evt_enable_bank #(
  parameter int unsigned NBYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] byte_we,
  input  logic [7:0]        wdata,
  output logic [7:0]        en_byte [NBYTES]
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_byte[b] <= 8'h00;
      else if (byte_we[b]) en_byte[b] <= wdata;
    end
  end
endmodule

// File: rtl/evt_regblk.sv
module evt_regblk
  import evt_regblk_pkg::*;
#(
  parameter int unsigned BLK_BYTES   = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BLK_BYTES*4-1:0]  evt_in,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic                    wr_en,
  input  logic                    rd_en,
  output logic [7:0]              rdata,
  output logic                    irq
);
  localparam int unsigned HALF  = BLK_BYTES / 2;
  localparam int unsigned NPINS = pin_count(BLK_BYTES);

  logic [31:0]      addr_w;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] sts_q;
  logic [NPINS-1:0] en_flat;
  logic [HALF-1:0]  en_we;
  logic [7:0]       en_byte [HALF];
  logic [7:0]       rd_byte;

  assign addr_w = 32'(addr);

  evt_edge_detect #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .rise(rise)
  );

  evt_status_bank #(.NPINS(NPINS)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(rise), .clr_vec(clr), .sts_q(sts_q)
  );

  evt_enable_bank #(.NBYTES(HALF)) u_en (
    .clk(clk), .rst_n(rst_n), .byte_we(en_we), .wdata(wdata), .en_byte(en_byte)
  );

  // Per-byte write decode for both halves.
  for (genvar b = 0; b < HALF; b++) begin : g_dec
    assign clr[b*8 +: 8] = (wr_en && (addr_w == 32'(b))) ? wdata : 8'h00;
    assign en_we[b]      = wr_en && (addr_w == 32'(HALF + b));
  end

  // Pin-to-byte mapping of the enable half.
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign en_flat[p] = en_byte[pin_byte(p)][pin_bit(p)];
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int b = 0; b < int'(HALF); b++) begin
      if (addr_w == 32'(b))        rd_byte = sts_q[b*8 +: 8];
      if (addr_w == 32'(HALF + b)) rd_byte = en_byte[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_byte;
  end

  assign irq = |(sts_q & en_flat);
endmodule

// File: rtl/evt_regblk_chk.sv
module evt_regblk_chk
  import evt_regblk_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 16,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NPINS     = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic [NPINS-1:0]  rise,
  input logic [NPINS-1:0]  clr,
  input logic [NPINS-1:0]  sts_q,
  input logic [NPINS-1:0]  en_flat
);
  initial begin
    AST_BLK_LEN: assert (blk_len_ok(BLK_BYTES)) else $error("bad BLK_BYTES"); // R1
  end

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((sts_q & $past(rise)) == $past(rise))); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(rise)) == '0)); // R2

  AST_CLEAR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_q) & ~sts_q & ~$past(clr)) == '0)); // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_flat)); // R5

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en)); // R6

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (32'(addr) >= BLK_BYTES)) |=> (rdata == 8'h00)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R8
endmodule

bind evt_regblk evt_regblk_chk #(
  .BLK_BYTES(BLK_BYTES), .ADDR_W(ADDR_W), .NPINS(NPINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .irq(irq), .rise(rise), .clr(clr), .sts_q(sts_q),
  .en_flat(en_flat)
);

// File: tb/evt_regblk_bench.sv
module evt_regblk_bench;
  localparam int unsigned BLK   = 6;
  localparam int unsigned AW    = 5;
  localparam int unsigned HALF  = BLK / 2;
  localparam int unsigned NPINS = HALF * 8;

  typedef struct { logic [7:0] data; string req; logic [AW-1:0] a; } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] evt_in = '0;
  logic [AW-1:0]    addr = '0;
  logic [7:0]       wdata = '0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [7:0]       rdata;
  logic             irq;

  int errors = 0;
  int checks = 0;
  exp_t q[$];
  logic [NPINS-1:0] m_sts = '0;
  logic [7:0]       m_en [HALF];

  always #10 clk = ~clk;

  evt_regblk #(.BLK_BYTES(BLK), .ADDR_W(AW), .SYNC_STAGES(2)) u_evt_regblk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  function automatic logic [7:0] model_byte(input int unsigned a);
    if (a < HALF) return m_sts[a*8 +: 8];
    if (a < BLK)  return m_en[a-HALF];
    return 8'h00;
  endfunction

  function automatic logic model_irq();
    for (int p = 0; p < int'(NPINS); p++)
      if (m_sts[p] && m_en[p/8][p%8]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int unsigned a, input string req);
    exp_t e;
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    e.data = model_byte(a); e.req = req; e.a = AW'(a);
    q.push_back(e);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input int unsigned a, input logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < HALF)     m_sts[a*8 +: 8] = m_sts[a*8 +: 8] & ~d;
    else if (a < BLK) m_en[a-HALF] = d;
  endtask

  task automatic pulse(input int unsigned p);
    @(negedge clk); evt_in[p] = 1'b1;
    repeat (4) @(negedge clk);
    evt_in[p] = 1'b0;
    repeat (4) @(negedge clk);
    m_sts[p] = 1'b1;
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    check({7'b0, irq}, {7'b0, model_irq()}, req);
  endtask

  // Monitor: compare each read result in the cycle after its strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8: actual=%h expected=<none>", rdata);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rdata, e.data, e.req);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] held;
    for (int b = 0; b < int'(HALF); b++) m_en[b] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state, R5 enables reset to zero
    check(rdata, 8'h00, "R8");
    chk_irq("R8");
    for (int a = 0; a < int'(BLK); a++) rd(a, a < int'(HALF) ? "R8" : "R5");

    // R2 sets regardless of enable; R1 byte/bit placement
    pulse(0); pulse(9); pulse(23);
    rd(0, "R1"); rd(1, "R1"); rd(2, "R2");
    chk_irq("R6");

    // R5/R6 unmask pin 9 (enable byte 1 at address 4, bit 1)
    wr(4, 8'h02);
    chk_irq("R6");
    rd(4, "R5");

    // R3 zeros have no effect, ones clear
    wr(1, 8'h00);
    rd(1, "R3");
    chk_irq("R6");
    wr(1, 8'h02);
    rd(1, "R3");
    chk_irq("R6");

    // R2 event on an enabled pin raises irq
    pulse(10);
    wr(4, 8'h06);
    chk_irq("R6");
    wr(4, 8'h02);
    chk_irq("R6");

    // R7 out-of-window accesses
    wr(7, 8'hFF); wr(31, 8'hFF); wr(BLK, 8'hFF);
    rd(7, "R7"); rd(31, "R7");
    for (int a = 0; a < int'(BLK); a++) rd(a, "R7");

    // R9 held level sets only once
    @(negedge clk); evt_in[5] = 1'b1;
    repeat (5) @(negedge clk);
    m_sts[5] = 1'b1;
    rd(0, "R9");
    wr(0, 8'h20);
    repeat (5) @(negedge clk);
    rd(0, "R9");
    @(negedge clk); evt_in[5] = 1'b0;
    repeat (4) @(negedge clk);

    // R4 rise coincides with an acknowledge of pin 0 (already set)
    @(negedge clk); evt_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = AW'(0); wdata = 8'h01; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(0, "R4");
    @(negedge clk); evt_in[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R8 rdata holds while rd_en is low
    rd(3, "R8");
    held = rdata;
    wr(3, 8'h21);
    repeat (2) @(negedge clk);
    check(rdata, held, "R8");
    rd(3, "R5");
    chk_irq("R6");
    wr(0, 8'h01);
    chk_irq("R6");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R8: actual=%0d expected=0 pending reads", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule